// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out the architectural bookkeeping when a processor core accepts a trap. A trap is either an asynchronous interrupt, which the core's priority logic has already accepted, or a synchronous exception raised by an instruction. On the clock edge that samples a request, the block does several things at once:

- It copies the status word, the return address and the stack register (R15) into shadow registers.
- It raises three control bits in the status word.
- It writes the event code into the event register for that trap class.
- It forms the handler address from the vector base.

A one-cycle done pulse then tells the core to fetch from the new PC.

The block is a two-state machine. In state READY it services requests. The transition READY to READY is taken either when a trap is entered or when the cycle is idle. The transition READY to HALTED is taken when an exception arrives while the status word's block bit is already set. Such a nested exception cannot be serviced safely, so the block stops. The transition HALTED to HALTED holds the block there until reset. In HALTED the fatal flag is driven high and every request is dropped.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, every output is zero: done, fatal, new_pc, sr_out, saved_sr, saved_pc, saved_stack, int_event and exc_event.
- R2: Consider an interrupt request that is taken on a clock edge. After that edge, saved_pc equals next_pc, int_event equals int_code, and new_pc equals vbr_in + 0x600. done is high for that one cycle.
- R3: Consider an exception whose code is not a translation-miss code, and which arrives while sr_in bit 28 is 0. After the edge, saved_pc equals exc_pc, exc_event equals exc_code, new_pc equals vbr_in + 0x100, and done pulses.
- R4: An exception with code 0x040 (translation miss on read) or 0x060 (translation miss on write) sets new_pc to vbr_in + 0x400.
- R5: On every serviced entry, saved_sr takes sr_in and saved_stack takes r15_in.
- R6: On every serviced entry, sr_out becomes sr_in with bits 28 (block), 29 (register bank) and 30 (privileged mode) forced to 1.
- R7: An interrupt entry leaves exc_event unchanged. An exception entry leaves int_event unchanged.
- R8: When int_req and exc_req are both high in the same cycle, only the exception is serviced. Its handler address and exc_event are produced, and int_event is unchanged.
- R9: An exception requested while sr_in bit 28 is 1 sets fatal and produces no done pulse. It leaves new_pc, sr_out, saved_sr, saved_pc, saved_stack, int_event and exc_event unchanged.
- R10: Once set, fatal stays high until reset. While it is high, every request is ignored, with no done pulse and no register change. After reset, service resumes.
- R11: done is high only in the cycle after a serviced request. Back-to-back requests each give their own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_req | input | 1 | Interrupt accept strobe |
| int_code | input | 12 | Interrupt event code |
| exc_req | input | 1 | Exception strobe |
| exc_code | input | 12 | Exception event code |
| exc_pc | input | 32 | Address of the faulting instruction |
| next_pc | input | 32 | Address of the next instruction to execute |
| sr_in | input | 32 | Current status word |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base address |
| done | output | 1 | One-cycle entry-complete pulse |
| new_pc | output | 32 | Handler address |
| sr_out | output | 32 | Status word after entry |
| saved_sr | output | 32 | Shadow copy of the status word |
| saved_pc | output | 32 | Shadow return address |
| saved_stack | output | 32 | Shadow copy of R15 |
| int_event | output | 12 | Last interrupt event code |
| exc_event | output | 12 | Last exception event code |
| fatal | output | 1 | Sticky nested-exception error flag |

## Verification
Two functions can fall in the same cycle: an interrupt entry and an exception entry. A second, related pairing is an exception together with the block-bit check that turns it fatal. The bench raises int_req and exc_req on the same edge with different codes and different return addresses. It then judges the outcome by four things: the handler offset is the exception's, exc_event and saved_pc carry the exception's values, int_event keeps its earlier value, and exactly one done pulse appears. It also raises an exception with the block bit set, after which the fatal flag must rise while every shadow, event and PC output stays frozen.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [0:0] {
        ST_READY  = 1'b0,
        ST_HALTED = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_INT   = 2'd1,
        EV_EXC   = 2'd2,
        EV_FATAL = 2'd3
    } entry_kind_e;

endpackage

// File: rtl/trap_select.sv
module trap_select
    import trap_entry_pkg::*;
(
    input  logic        int_req,
    input  logic        exc_req,
    input  logic        blocked,
    input  logic        halted,
    output entry_kind_e kind
);

    // Exceptions win over interrupts; a blocked exception is fatal.
    always_comb begin
        if (halted) begin
            kind = EV_NONE;
        end else if (exc_req) begin
            kind = blocked ? EV_FATAL : EV_EXC;
        end else if (int_req) begin
            kind = EV_INT;
        end else begin
            kind = EV_NONE;
        end
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12,
    parameter logic [XLEN-1:0]   INT_OFS     = 32'h600,
    parameter logic [XLEN-1:0]   GEN_OFS     = 32'h100,
    parameter logic [XLEN-1:0]   MISS_OFS    = 32'h400,
    parameter logic [CODE_W-1:0] MISS_RD_CODE = 12'h040,
    parameter logic [CODE_W-1:0] MISS_WR_CODE = 12'h060
) (
    input  logic              is_int,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   vbr,
    output logic [XLEN-1:0]   handler
);

    localparam int N_MISS = 2;

    logic [CODE_W-1:0] miss_codes [N_MISS];
    logic [N_MISS-1:0] miss_hit;
    logic [XLEN-1:0]   offset;

    assign miss_codes[0] = MISS_RD_CODE;
    assign miss_codes[1] = MISS_WR_CODE;

    for (genvar g = 0; g < N_MISS; g++) begin : g_miss
        assign miss_hit[g] = (code == miss_codes[g]);
    end

    always_comb begin
        if (is_int) begin
            offset = INT_OFS;
        end else if (|miss_hit) begin
            offset = MISS_OFS;
        end else begin
            offset = GEN_OFS;
        end
    end

    assign handler = vbr + offset;

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CODE_W  = 12,
    parameter int BL_BIT  = 28,
    parameter int RB_BIT  = 29,
    parameter int MD_BIT  = 30,
    parameter logic [XLEN-1:0]   INT_OFS      = 32'h600,
    parameter logic [XLEN-1:0]   GEN_OFS      = 32'h100,
    parameter logic [XLEN-1:0]   MISS_OFS     = 32'h400,
    parameter logic [CODE_W-1:0] MISS_RD_CODE = 12'h040,
    parameter logic [CODE_W-1:0] MISS_WR_CODE = 12'h060
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_req,
    input  logic [CODE_W-1:0] int_code,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic              done,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   saved_sr,
    output logic [XLEN-1:0]   saved_pc,
    output logic [XLEN-1:0]   saved_stack,
    output logic [CODE_W-1:0] int_event,
    output logic [CODE_W-1:0] exc_event,
    output logic              fatal
);

    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << BL_BIT) | (XLEN'(1) << RB_BIT) | (XLEN'(1) << MD_BIT);

    seq_state_e  state_q, state_d;
    entry_kind_e kind;
    logic [XLEN-1:0] handler;

    trap_select u_select (
        .int_req (int_req),
        .exc_req (exc_req),
        .blocked (sr_in[BL_BIT]),
        .halted  (state_q == ST_HALTED),
        .kind    (kind)
    );

    trap_vector #(
        .XLEN        (XLEN),
        .CODE_W      (CODE_W),
        .INT_OFS     (INT_OFS),
        .GEN_OFS     (GEN_OFS),
        .MISS_OFS    (MISS_OFS),
        .MISS_RD_CODE(MISS_RD_CODE),
        .MISS_WR_CODE(MISS_WR_CODE)
    ) u_vector (
        .is_int  (kind == EV_INT),
        .code    (exc_code),
        .vbr     (vbr_in),
        .handler (handler)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:  if (kind == EV_FATAL) state_d = ST_HALTED;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    assign fatal = (state_q == ST_HALTED);

    // Architectural outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            new_pc      <= '0;
            sr_out      <= '0;
            saved_sr    <= '0;
            saved_pc    <= '0;
            saved_stack <= '0;
            int_event   <= '0;
            exc_event   <= '0;
        end else begin
            done <= 1'b0;
            unique case (kind)
                EV_INT: begin
                    done        <= 1'b1;
                    new_pc      <= handler;
                    sr_out      <= sr_in | ENTRY_SET;
                    saved_sr    <= sr_in;
                    saved_stack <= r15_in;
                    saved_pc    <= next_pc;
                    int_event   <= int_code;
                end
                EV_EXC: begin
                    done        <= 1'b1;
                    new_pc      <= handler;
                    sr_out      <= sr_in | ENTRY_SET;
                    saved_sr    <= sr_in;
                    saved_stack <= r15_in;
                    saved_pc    <= exc_pc;
                    exc_event   <= exc_code;
                end
                EV_FATAL: ;
                EV_NONE:  ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12,
    parameter int BL_BIT = 28,
    parameter int RB_BIT = 29,
    parameter int MD_BIT = 30,
    parameter logic [XLEN-1:0] INT_OFS = 32'h600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_req,
    input logic [CODE_W-1:0] int_code,
    input logic              exc_req,
    input logic [CODE_W-1:0] exc_code,
    input logic [XLEN-1:0]   exc_pc,
    input logic [XLEN-1:0]   next_pc,
    input logic [XLEN-1:0]   sr_in,
    input logic [XLEN-1:0]   r15_in,
    input logic [XLEN-1:0]   vbr_in,
    input logic              done,
    input logic [XLEN-1:0]   new_pc,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   saved_sr,
    input logic [XLEN-1:0]   saved_pc,
    input logic [XLEN-1:0]   saved_stack,
    input logic [CODE_W-1:0] int_event,
    input logic [CODE_W-1:0] exc_event,
    input logic              fatal
);

    assert_int_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !exc_req && !fatal) |=>
            (done && saved_pc == $past(next_pc) && int_event == $past(int_code)
             && new_pc == $past(vbr_in) + INT_OFS));

    assert_exc_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !sr_in[BL_BIT] && !fatal) |=>
            (done && saved_pc == $past(exc_pc) && exc_event == $past(exc_code)));

    assert_shadow_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_req || exc_req) && !fatal && !(exc_req && sr_in[BL_BIT])) |=>
            (saved_sr == $past(sr_in) && saved_stack == $past(r15_in)));

    assert_sr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sr_out[BL_BIT] && sr_out[RB_BIT] && sr_out[MD_BIT]));

    assert_int_kept_on_exc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !fatal) |=> $stable(int_event));

    assert_fatal_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && sr_in[BL_BIT] && !fatal) |=>
            (fatal && !done && $stable(new_pc) && $stable(saved_pc)
             && $stable(exc_event) && $stable(sr_out)));

    assert_fatal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> (fatal && !done));

    assert_done_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_req || exc_req) |=> !done);

endmodule

bind trap_entry_seq trap_entry_chk #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W),
    .BL_BIT (BL_BIT),
    .RB_BIT (RB_BIT),
    .MD_BIT (MD_BIT),
    .INT_OFS(INT_OFS)
) i_trap_entry_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_req    (int_req),
    .int_code   (int_code),
    .exc_req    (exc_req),
    .exc_code   (exc_code),
    .exc_pc     (exc_pc),
    .next_pc    (next_pc),
    .sr_in      (sr_in),
    .r15_in     (r15_in),
    .vbr_in     (vbr_in),
    .done       (done),
    .new_pc     (new_pc),
    .sr_out     (sr_out),
    .saved_sr   (saved_sr),
    .saved_pc   (saved_pc),
    .saved_stack(saved_stack),
    .int_event  (int_event),
    .exc_event  (exc_event),
    .fatal      (fatal)
);

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_req = 1'b0;
    logic [11:0] int_code = '0;
    logic        exc_req = 1'b0;
    logic [11:0] exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] next_pc = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] r15_in = '0;
    logic [31:0] vbr_in = '0;
    logic        done;
    logic [31:0] new_pc, sr_out, saved_sr, saved_pc, saved_stack;
    logic [11:0] int_event, exc_event;
    logic        fatal;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    trap_entry_seq i_trap_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .int_req(int_req), .int_code(int_code),
        .exc_req(exc_req), .exc_code(exc_code), .exc_pc(exc_pc),
        .next_pc(next_pc), .sr_in(sr_in), .r15_in(r15_in), .vbr_in(vbr_in),
        .done(done), .new_pc(new_pc), .sr_out(sr_out), .saved_sr(saved_sr),
        .saved_pc(saved_pc), .saved_stack(saved_stack),
        .int_event(int_event), .exc_event(exc_event), .fatal(fatal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exc_target(input logic [31:0] vbr, input logic [11:0] code);
        return vbr + ((code == 12'h040 || code == 12'h060) ? 32'h400 : 32'h100);
    endfunction

    // Drive one request cycle; returns just after the sampling edge.
    task automatic fire(input logic ir, input logic [11:0] ic,
                        input logic er, input logic [11:0] ec, input logic [31:0] epc);
        @(negedge clk);
        int_req = ir; int_code = ic; exc_req = er; exc_code = ec; exc_pc = epc;
        @(posedge clk);
        #1;
        int_req = 1'b0; exc_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        int_req = 1'b0; exc_req = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "fatal", 32'(fatal), 32'd0);
        chk("R1", "new_pc", new_pc, 32'd0);
        chk("R1", "sr_out", sr_out, 32'd0);
        chk("R1", "saved_sr", saved_sr, 32'd0);
        chk("R1", "saved_pc", saved_pc, 32'd0);
        chk("R1", "saved_stack", saved_stack, 32'd0);
        chk("R1", "int_event", 32'(int_event), 32'd0);
        chk("R1", "exc_event", 32'(exc_event), 32'd0);
    endtask

    task automatic t_interrupt();
        logic [11:0] exc_before;
        exc_before = exc_event;
        next_pc = 32'h8C00_1234; sr_in = 32'h0000_00F1; r15_in = 32'h0CFF_FF00;
        vbr_in = 32'h8C00_0000;
        fire(1'b1, 12'h320, 1'b0, 12'h0, 32'h0);
        chk("R2", "done", 32'(done), 32'd1);
        chk("R2", "saved_pc", saved_pc, 32'h8C00_1234);
        chk("R2", "int_event", 32'(int_event), 32'h320);
        chk("R2", "new_pc", new_pc, 32'h8C00_0600);
        chk("R5", "saved_sr", saved_sr, 32'h0000_00F1);
        chk("R5", "saved_stack", saved_stack, 32'h0CFF_FF00);
        chk("R6", "sr_out", sr_out, 32'h7000_00F1);
        chk("R7", "exc_event kept", 32'(exc_event), 32'(exc_before));
        @(posedge clk); #1;
        chk("R11", "done drops", 32'(done), 32'd0);
    endtask

    task automatic t_exc_general();
        logic [11:0] int_before;
        int_before = int_event;
        sr_in = 32'h8000_0003; r15_in = 32'h1111_2222; vbr_in = 32'hA000_1000;
        fire(1'b0, 12'h0, 1'b1, 12'h180, 32'h8C00_4000);
        chk("R3", "done", 32'(done), 32'd1);
        chk("R3", "saved_pc", saved_pc, 32'h8C00_4000);
        chk("R3", "exc_event", 32'(exc_event), 32'h180);
        chk("R3", "new_pc", new_pc, exc_target(32'hA000_1000, 12'h180));
        chk("R5", "saved_sr", saved_sr, 32'h8000_0003);
        chk("R5", "saved_stack", saved_stack, 32'h1111_2222);
        chk("R6", "sr_out", sr_out, 32'hF000_0003);
        chk("R7", "int_event kept", 32'(int_event), 32'(int_before));
    endtask

    task automatic t_exc_miss();
        vbr_in = 32'h0000_2000; sr_in = 32'h0;
        fire(1'b0, 12'h0, 1'b1, 12'h040, 32'h0000_0100);
        chk("R4", "read miss new_pc", new_pc, 32'h0000_2400);
        fire(1'b0, 12'h0, 1'b1, 12'h060, 32'h0000_0104);
        chk("R4", "write miss new_pc", new_pc, 32'h0000_2400);
        chk("R11", "back-to-back done", 32'(done), 32'd1);
        fire(1'b0, 12'h0, 1'b1, 12'h0E0, 32'h0000_0108);
        chk("R4", "other code new_pc", new_pc, 32'h0000_2100);
        chk("R11", "third done", 32'(done), 32'd1);
    endtask

    task automatic t_simultaneous();
        logic [11:0] int_before;
        int_before = int_event;
        vbr_in = 32'h4000_0000; next_pc = 32'h5555_0000; sr_in = 32'h0000_0010;
        fire(1'b1, 12'h3C0, 1'b1, 12'h1A0, 32'h6666_0000);
        chk("R8", "new_pc", new_pc, 32'h4000_0100);
        chk("R8", "exc_event", 32'(exc_event), 32'h1A0);
        chk("R8", "saved_pc", saved_pc, 32'h6666_0000);
        chk("R8", "int_event kept", 32'(int_event), 32'(int_before));
        chk("R8", "done", 32'(done), 32'd1);
        @(posedge clk); #1;
        chk("R8", "single pulse", 32'(done), 32'd0);
    endtask

    task automatic t_fatal();
        logic [31:0] pc0, sr0, ssr0, spc0, sst0;
        logic [11:0] ie0, ee0;
        pc0 = new_pc; sr0 = sr_out; ssr0 = saved_sr; spc0 = saved_pc;
        sst0 = saved_stack; ie0 = int_event; ee0 = exc_event;
        sr_in = 32'h1000_0000; r15_in = 32'hDEAD_0000; vbr_in = 32'h7700_0000;
        fire(1'b1, 12'h200, 1'b1, 12'h1E0, 32'h9999_0000);
        chk("R9", "fatal", 32'(fatal), 32'd1);
        chk("R9", "no done", 32'(done), 32'd0);
        chk("R9", "new_pc", new_pc, pc0);
        chk("R9", "sr_out", sr_out, sr0);
        chk("R9", "saved_sr", saved_sr, ssr0);
        chk("R9", "saved_pc", saved_pc, spc0);
        chk("R9", "saved_stack", saved_stack, sst0);
        chk("R9", "int_event", 32'(int_event), 32'(ie0));
        chk("R9", "exc_event", 32'(exc_event), 32'(ee0));
        sr_in = 32'h0;
        fire(1'b1, 12'h240, 1'b0, 12'h0, 32'h0);
        chk("R10", "fatal held", 32'(fatal), 32'd1);
        chk("R10", "no done", 32'(done), 32'd0);
        chk("R10", "int_event", 32'(int_event), 32'(ie0));
        fire(1'b0, 12'h0, 1'b1, 12'h100, 32'h1234_0000);
        chk("R10", "exc ignored", 32'(exc_event), 32'(ee0));
        chk("R10", "new_pc", new_pc, pc0);
        do_reset();
        chk("R10", "fatal cleared", 32'(fatal), 32'd0);
        vbr_in = 32'h0000_8000; next_pc = 32'h0000_0042;
        fire(1'b1, 12'h260, 1'b0, 12'h0, 32'h0);
        chk("R10", "service resumes", new_pc, 32'h0000_8600);
        chk("R10", "done after reset", 32'(done), 32'd1);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_interrupt();
        t_exc_general();
        t_exc_miss();
        t_simultaneous();
        t_fatal();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule